// File: doc/BRIEF.md
# Fixed-Point Plane Rotator

This unit performs one plane rotation step for a fast 8-point transform datapath. Two signed 16-bit operands `a` and `b` and a 2-bit rotation selector enter together. Two cycles later the unit returns the rotated pair:
- `out_c = a*kc + b*ks`
- `out_d = b*kc - a*ks`

Here `kc` and `ks` are the scaled cosine and sine of the selected angle. They are held as unsigned 16-bit fractions with 15 fractional bits, and none of them is larger than 1.0.

The rotation uses a shared-product form with three multipliers instead of four:
- A common term `t = kc*(a+b)` is formed once.
- Each output then subtracts one more product from `t`.

The three products are exact in a 32-bit accumulator. Each output sum is rounded once to 16 bits and clipped to the signed range, so precision is lost only at that final step. Both output registers load only on a valid transfer. The unit accepts a new operand pair every cycle.

Top module: `fixed_rotator`

## Requirements
- R1: The latency is two clock cycles. A pair presented with `in_valid` high at a rising edge produces `out_valid` high and its results after the second rising edge, and back-to-back pairs produce back-to-back results.
- R2: `out_c` equals `clip((a*kc + b*ks + 16384) >> 15)`. Here `>>` is an arithmetic shift (floor), so exact halves round toward plus infinity.
- R3: `out_d` equals `clip((b*kc - a*ks + 16384) >> 15)`, with the same single rounding step as R2.
- R4: The `sel` encoding, with values in Q15, is:
  - 0: angle pi/16, kc=32138, ks=6393
  - 1: angle 3pi/16, kc=27246, ks=18205
  - 2: angle 6pi/16, kc=12540, ks=30274
  - 3: identity, kc=32768, ks=0, so `out_c=a` and `out_d=b`
- R5: The full-scale operands -32768 and 32767 give exact results for every selector. No intermediate wrap-around shows in the outputs.
- R6: `clip` saturates to the range -32768..32767. Any rounded sum above 32767 gives 32767, and any below -32768 gives -32768.
- R7: A synchronous active-high `rst` drives `out_valid`, `out_c` and `out_d` to 0.
- R8: While no valid pair reaches the output stage, `out_c` and `out_d` keep their previous values and `out_valid` is low, whatever `a`, `b` and `sel` do.
- R9: Zero operands give zero results for every selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and selector are valid this cycle |
| sel | input | 2 | Rotation selector (R4 encoding) |
| a | input | 16 | First operand, signed two's complement |
| b | input | 16 | Second operand, signed two's complement |
| out_valid | output | 1 | Results are valid, two cycles after the input |
| out_c | output | 16 | Rotated first output, signed |
| out_d | output | 16 | Rotated second output, signed |

## Verification
The assertions check the following on every cycle:
- `out_valid` is always backed by a valid input two cycles earlier.
- The identity selector returns its operands unchanged.
- Zero operands produce zero results.
- The outputs hold steady when the output stage is not loaded.
- Each output lane clips when its accumulated sum lies beyond the representable range.

Only the bench's sweep can show that the three-product form reproduces the four-product rotation bit for bit. It runs corner operands (full scale, one below, small and mid-range values) across every selector, compared against an independent integer model. The sweep also covers the rounding of exact halves and pipelined streaming of consecutive pairs.

// File: rtl/rot_pkg.sv
package rot_pkg;

    // Datapath configuration
    localparam int DATA_W    = 16;              // operand and result width
    localparam int COEF_W    = 16;              // unsigned coefficient width
    localparam int FRAC_W    = 15;              // fractional bits of coefficients
    localparam int ACC_W     = 32;              // internal accumulator width
    localparam int SEL_W     = 2;               // rotation selector width
    localparam int NUM_LANES = 2;               // two rotated outputs
    localparam int SUM_W     = DATA_W + 1;      // width of a+b
    localparam int KD_W      = COEF_W + 1;      // signed width of kc-ks
    localparam int KS_W      = COEF_W + 1;      // unsigned width of kc+ks

    // Rotation selector encoding
    typedef enum logic [SEL_W-1:0] {
        ROT_PI_16   = 2'd0,
        ROT_3PI_16  = 2'd1,
        ROT_6PI_16  = 2'd2,
        ROT_IDENT   = 2'd3
    } rot_sel_e;

    // Derived coefficients for the three-product form
    typedef struct packed {
        logic        [COEF_W-1:0] kc;     // k*cos
        logic signed [KD_W-1:0]   kdiff;  // k*cos - k*sin
        logic        [KS_W-1:0]   ksum;   // k*cos + k*sin
    } coef_t;

    // Registered products of the first pipeline stage
    typedef struct packed {
        logic signed [ACC_W-1:0] shared;  // kc*(a+b)
        logic signed [ACC_W-1:0] prod_b;  // (kc-ks)*b
        logic signed [ACC_W-1:0] prod_a;  // (kc+ks)*a
    } prod_t;

    // Q15 cosine of the selected angle
    function automatic logic [COEF_W-1:0] coef_cos(rot_sel_e s);
        case (s)
            ROT_PI_16:  return COEF_W'(32138);
            ROT_3PI_16: return COEF_W'(27246);
            ROT_6PI_16: return COEF_W'(12540);
            default:    return COEF_W'(1 << FRAC_W);
        endcase
    endfunction

    // Q15 sine of the selected angle
    function automatic logic [COEF_W-1:0] coef_sin(rot_sel_e s);
        case (s)
            ROT_PI_16:  return COEF_W'(6393);
            ROT_3PI_16: return COEF_W'(18205);
            ROT_6PI_16: return COEF_W'(30274);
            default:    return COEF_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/rot_coef_rom.sv
module rot_coef_rom
    import rot_pkg::*;
(
    input  rot_sel_e sel,
    output coef_t    coef
);

    logic [COEF_W-1:0] kc;
    logic [COEF_W-1:0] ks;

    always_comb begin
        kc         = coef_cos(sel);
        ks         = coef_sin(sel);
        coef.kc    = kc;
        coef.kdiff = $signed({1'b0, kc}) - $signed({1'b0, ks});
        coef.ksum  = {1'b0, kc} + {1'b0, ks};
    end

endmodule

// File: rtl/rot_mult_stage.sv
module rot_mult_stage
    import rot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  coef_t                    coef,
    output prod_t                    prod
);

    logic signed [SUM_W-1:0] sum_ab;
    logic signed [ACC_W-1:0] op_sum;
    logic signed [ACC_W-1:0] op_a;
    logic signed [ACC_W-1:0] op_b;
    logic signed [ACC_W-1:0] op_kc;
    logic signed [ACC_W-1:0] op_kdiff;
    logic signed [ACC_W-1:0] op_ksum;
    prod_t                   prod_next;

    // Operands widened to the accumulator. Every product is exact in ACC_W.
    always_comb begin
        sum_ab   = SUM_W'(a) + SUM_W'(b);
        op_sum   = ACC_W'(sum_ab);
        op_a     = ACC_W'(a);
        op_b     = ACC_W'(b);
        op_kc    = $signed(ACC_W'(coef.kc));
        op_kdiff = ACC_W'(coef.kdiff);
        op_ksum  = $signed(ACC_W'(coef.ksum));
        prod_next.shared = op_sum * op_kc;
        prod_next.prod_b = op_b * op_kdiff;
        prod_next.prod_a = op_a * op_ksum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else if (en) begin
            prod <= prod_next;
        end
    end

endmodule

// File: rtl/rot_round_sat.sv
module rot_round_sat
    import rot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [ACC_W-1:0]  shared,
    input  logic signed [ACC_W-1:0]  sub,
    output logic signed [DATA_W-1:0] y
);

    localparam longint OUT_MAX  = (longint'(1) << (DATA_W-1)) - 1;
    localparam longint OUT_MIN  = -(longint'(1) << (DATA_W-1));
    localparam longint HALF_LSB = longint'(1) << (FRAC_W-1);
    localparam longint HI_EDGE  = (OUT_MAX << FRAC_W) + HALF_LSB;
    localparam longint LO_EDGE  = (OUT_MIN << FRAC_W) - HALF_LSB;

    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W:0]    rnd;
    logic signed [ACC_W:0]    shifted;
    logic signed [DATA_W-1:0] y_next;

    // One subtraction, one rounding add, one clip
    always_comb begin
        acc     = shared - sub;
        rnd     = (ACC_W+1)'(acc) + (ACC_W+1)'(HALF_LSB);
        shifted = rnd >>> FRAC_W;
        if (shifted > (ACC_W+1)'(OUT_MAX)) begin
            y_next = DATA_W'(OUT_MAX);
        end else if (shifted < (ACC_W+1)'(OUT_MIN)) begin
            y_next = DATA_W'(OUT_MIN);
        end else begin
            y_next = shifted[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (en) begin
            y <= y_next;
        end
    end

    // R6: a sum at or above the upper rounding edge clips to the maximum
    a_r6_clip_high: assert property (@(posedge clk) disable iff (rst)
        (en && longint'(acc) >= HI_EDGE) |=> (y == DATA_W'(OUT_MAX)));

    // R6: a sum below the lower rounding edge clips to the minimum
    a_r6_clip_low: assert property (@(posedge clk) disable iff (rst)
        (en && longint'(acc) < LO_EDGE) |=> (y == DATA_W'(OUT_MIN)));

endmodule

// File: rtl/fixed_rotator.sv
module fixed_rotator
    import rot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [SEL_W-1:0]         sel,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_c,
    output logic signed [DATA_W-1:0] out_d
);

    coef_t                   coef;
    prod_t                   prod;
    logic                    mid_valid;
    logic signed [ACC_W-1:0]  lane_sub [NUM_LANES];
    logic signed [DATA_W-1:0] lane_y   [NUM_LANES];

    rot_coef_rom u_rom (
        .sel  (rot_sel_e'(sel)),
        .coef (coef)
    );

    rot_mult_stage u_mult (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .a    (a),
        .b    (b),
        .coef (coef),
        .prod (prod)
    );

    // Lane 0 removes (kc-ks)*b to give out_c; lane 1 removes (kc+ks)*a to give out_d
    assign lane_sub[0] = prod.prod_b;
    assign lane_sub[1] = prod.prod_a;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        rot_round_sat u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (mid_valid),
            .shared (prod.shared),
            .sub    (lane_sub[g]),
            .y      (lane_y[g])
        );
    end

    assign out_c = lane_y[0];
    assign out_d = lane_y[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            mid_valid <= in_valid;
            out_valid <= mid_valid;
        end
    end

    // R1: every result has a valid input two cycles before it
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R4: the identity selector passes both operands through unchanged
    a_r4_identity: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(sel, 2) == ROT_IDENT) |->
            (out_c == $past(a, 2) && out_d == $past(b, 2)));

    // R9: zero operands give zero results
    a_r9_zero_in: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(a, 2) == 0 && $past(b, 2) == 0) |->
            (out_c == 0 && out_d == 0));

    // R8: outputs hold when the output stage is not loaded
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(mid_valid) |-> ($stable(out_c) && $stable(out_d)));

endmodule

// File: tb/fixed_rotator_test.sv
module fixed_rotator_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [1:0]         sel = 2'd0;
    logic signed [15:0] a = '0;
    logic signed [15:0] b = '0;
    logic               out_valid;
    logic signed [15:0] out_c;
    logic signed [15:0] out_d;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    fixed_rotator uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sel       (sel),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .out_c     (out_c),
        .out_d     (out_d)
    );

    // R4 constant table
    function automatic int kc_of(int s);
        case (s)
            0: return 32138;
            1: return 27246;
            2: return 12540;
            default: return 32768;
        endcase
    endfunction

    function automatic int ks_of(int s);
        case (s)
            0: return 6393;
            1: return 18205;
            2: return 30274;
            default: return 0;
        endcase
    endfunction

    // Four-product reference with a single round-half-up and clip (R2, R3, R6)
    function automatic int model(int x, int y, int kx, int ky);
        longint s;
        longint r;
        s = longint'(x) * kx + longint'(y) * ky;
        r = (s + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic drive(int s, int x, int y);
        sel      = 2'(s);
        a        = 16'(x);
        b        = 16'(y);
        in_valid = 1'b1;
    endtask

    task automatic check_pair(string tag, int s, int x, int y);
        check({tag, " R2 out_c"}, int'(out_c), model(x, y, kc_of(s), ks_of(s)));
        check({tag, " R3 out_d"}, int'(out_d), model(y, x, kc_of(s), -ks_of(s)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int vals[12] = '{-32768, -32767, -16384, -1, 0, 1, 2, 100, 12345, 16384, 32766, 32767};
        int last_c;
        int last_d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check("R7 out_valid", int'(out_valid), 0);
        check("R7 out_c", int'(out_c), 0);
        check("R7 out_d", int'(out_d), 0);

        // R2 R3 R4 R5 R6 R9: sweep corner operands over every selector
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    drive(s, vals[i], vals[j]);
                    @(negedge clk);
                    in_valid = 1'b0;
                    @(negedge clk);
                    check("R1 out_valid", int'(out_valid), 1);
                    check_pair("R5 sweep", s, vals[i], vals[j]);
                end
            end
        end

        // R4: identity selector returns operands directly
        drive(3, -32768, 32767);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R4 identity c", int'(out_c), -32768);
        check("R4 identity d", int'(out_d), 32767);

        // R6: saturation of a large positive and a large negative sum
        drive(0, 32767, 32767);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 clip high", int'(out_c), 32767);
        drive(0, -32768, -32768);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 clip low", int'(out_c), -32768);

        // R1: back-to-back pairs come out on consecutive cycles
        drive(1, 1000, -2000);
        @(negedge clk);
        drive(2, -3000, 4000);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 stream first valid", int'(out_valid), 1);
        check_pair("R1 stream first", 1, 1000, -2000);
        @(negedge clk);
        check("R1 stream second valid", int'(out_valid), 1);
        check_pair("R1 stream second", 2, -3000, 4000);

        // R8: no valid input means held outputs and low out_valid
        last_c = int'(out_c);
        last_d = int'(out_d);
        for (int k = 0; k < 4; k++) begin
            sel = 2'(k);
            a   = 16'(7777 * (k + 1));
            b   = 16'(-5555 * (k + 1));
            @(negedge clk);
            check("R8 out_valid low", int'(out_valid), 0);
            check("R8 out_c held", int'(out_c), last_c);
            check("R8 out_d held", int'(out_d), last_d);
        end

        // R7: reset mid-run clears the outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 out_c after reset", int'(out_c), 0);
        check("R7 out_d after reset", int'(out_d), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule